// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides whether a far-pointer load may proceed. Such a load moves a 16-bit selector into one of the data or stack segment registers and a 16- or 32-bit offset into a general register. The surrounding pipeline supplies four groups of inputs each cycle a request is valid:

- the decoded request: target register, operating mode, operand size and whether the source operand was a register;
- the selector and the current privilege level;
- the already fetched descriptor attributes;
- two flags from the descriptor-table walk.

The block performs no memory access of its own.

One clock after a request, the block answers with a single registered result. When the load is legal it raises write enables for both registers and says whether the offset written is 16 or 32 bits wide. When the load is illegal it returns a fault class and the selector error code, and it suppresses both writes. The stack segment is checked against stricter rules than the four data segment registers:

- it must be a writable data segment;
- both its RPL and its DPL must equal CPL;
- its own fault class is used when it is absent.

A null selector is always accepted for the data registers. For the stack register it is accepted only in 64-bit mode below privilege 3.

Top module: `segload_check`

## Requirements
- R1: A request with `req_valid_i` high produces `rsp_valid_o` high exactly one clock later. A cycle without a request, and reset, give all outputs zero.
- R2: Fault code 1 (invalid opcode) is returned, with error selector 0, in any of these cases: the source is a register; the target code is 5, 6 or 7; or the target is DS (code 0) or ES (code 1) while mode is 3 (64-bit). Target codes: 0 DS, 1 ES, 2 FS, 3 GS, 4 SS. Modes: 0 real, 1 virtual-8086, 2 protected, 3 64-bit.
- R3: `seg_we_o` and `gpr_we_o` are high together exactly when a response carries fault 0. Operand-size code 0 writes a 16-bit offset (`off_wide_o` 0). Codes 1 to 3 write a 32-bit offset (`off_wide_o` 1), so a 64-bit size still writes 32 bits. `off_wide_o` is 0 whenever no load occurs.
- R4: In modes 0 and 1, no descriptor, table or privilege input has any effect. Every request that is not an R2 case loads.
- R5: In modes 2 and 3, a non-null selector raises fault code 2 (general protection) in two cases: `tbl_over_i` is high, or selector bit 2 (table indicator) is set while `ldt_null_i` is high. Selector fields are: RPL in bits 1:0, table indicator in bit 2, index in bits 15:3. A selector is null when bits 15:2 are zero. For every fault other than code 1, the error selector is the selector with bits 1:0 cleared.
- R6: A null selector loaded into DS, ES, FS or GS is accepted with no further checks. A null selector for SS raises fault 2 when the mode is not 3 or CPL is 3, and is accepted otherwise.
- R7: For SS, the descriptor must be a writable data segment, otherwise fault 2. Descriptor kind codes are: 1 data, 2 code, 0 or 3 system. `desc_rw_i` means writable for data and readable for code.
- R8: For SS, the selector RPL and the descriptor DPL must both equal CPL, otherwise fault 2.
- R9: For SS, a descriptor that is not present raises fault code 3 (stack fault).
- R10: For DS, ES, FS and GS, the descriptor must be data or readable code, otherwise fault 2.
- R11: For DS, ES, FS and GS that point at data or at non-conforming code, RPL > DPL or CPL > DPL raises fault 2. Conforming code is exempt from this check.
- R12: For DS, ES, FS and GS, a descriptor that is not present raises fault code 4 (segment not present).
- R13: When several faults apply, the first in this order is reported: invalid opcode, table checks, null-selector rule, type, privilege, presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| tgt_i | input | 3 | Target segment register code |
| mode_i | input | 2 | Operating mode code |
| opsize_i | input | 2 | Operand size: 0 16-bit, 1 32-bit, 2 64-bit |
| src_is_reg_i | input | 1 | Source operand was a register |
| selector_i | input | 16 | Selector being loaded |
| cpl_i | input | 2 | Current privilege level |
| desc_kind_i | input | 2 | Descriptor kind code |
| desc_present_i | input | 1 | Descriptor present bit |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| desc_rw_i | input | 1 | Writable (data) or readable (code) |
| desc_conforming_i | input | 1 | Code segment is conforming |
| tbl_over_i | input | 1 | Descriptor lies beyond its table limit |
| ldt_null_i | input | 1 | Local descriptor table selector is null |
| rsp_valid_o | output | 1 | Response present |
| seg_we_o | output | 1 | Segment register write enable |
| gpr_we_o | output | 1 | General register write enable |
| off_wide_o | output | 1 | Offset written is 32 bits |
| fault_o | output | 3 | Fault code (0 none) |
| err_sel_o | output | 16 | Error selector for the fault |

## Verification
The assertions check these on every cycle:

- the one-cycle response timing and the quiet idle state;
- that register-source requests always give an invalid-opcode fault;
- that the write enables agree with a zero fault code, and that a 16-bit operand never writes a wide offset;
- that real-mode loads always succeed;
- that every protection fault carries the request's selector with RPL cleared.

The ordering among table, null, type, privilege and presence faults can only be shown by the bench's directed and randomized scenarios. The same holds for the separate stack and data rule sets and for the null-selector cases, with the reference model deciding each expected fault.

// File: rtl/srl_pkg.sv
package srl_pkg;

    localparam int TGT_W  = 3;
    localparam int MODE_W = 2;
    localparam int PL_W   = 2;
    localparam int KIND_W = 2;
    localparam int FLT_W  = 3;

    localparam logic [TGT_W-1:0] TGT_DS = 3'd0;
    localparam logic [TGT_W-1:0] TGT_ES = 3'd1;
    localparam logic [TGT_W-1:0] TGT_SS = 3'd4;

    localparam logic [MODE_W-1:0] MODE_REAL = 2'd0;
    localparam logic [MODE_W-1:0] MODE_V86  = 2'd1;
    localparam logic [MODE_W-1:0] MODE_PROT = 2'd2;
    localparam logic [MODE_W-1:0] MODE_L64  = 2'd3;

    localparam logic [KIND_W-1:0] KIND_DATA = 2'd1;
    localparam logic [KIND_W-1:0] KIND_CODE = 2'd2;

    localparam logic [PL_W-1:0] PL_USER = 2'd3;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_GP   = 3'd2,
        FLT_SS   = 3'd3,
        FLT_NP   = 3'd4
    } fault_e;

    typedef struct packed {
        logic   ud;
        logic   desc_mode;
        logic   is_stack;
        logic   tbl_bad;
        logic   null_bad;
        logic   null_ok;
        logic   type_bad;
        logic   priv_bad;
        logic   absent;
    } chk_flags_t;

endpackage

// File: rtl/srl_sel_decode.sv
module srl_sel_decode #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [1:0]       rpl_o,
    output logic             ti_o,
    output logic             is_null_o,
    output logic [SEL_W-1:0] err_sel_o
);
    localparam int TI_BIT  = 2;
    localparam int IDX_LSB = 3;

    always_comb begin
        rpl_o     = sel_i[1:0];
        ti_o      = sel_i[TI_BIT];
        is_null_o = (sel_i[SEL_W-1:IDX_LSB] == '0) && !sel_i[TI_BIT];
        err_sel_o = {sel_i[SEL_W-1:TI_BIT], 2'b00};
    end
endmodule

// File: rtl/srl_seg_rules.sv
module srl_seg_rules
    import srl_pkg::*;
#(
    parameter bit IS_STACK = 1'b0
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic              rw_i,
    input  logic              conforming_i,
    input  logic              present_i,
    input  logic [PL_W-1:0]   dpl_i,
    input  logic [PL_W-1:0]   rpl_i,
    input  logic [PL_W-1:0]   cpl_i,
    output logic              type_bad_o,
    output logic              priv_bad_o,
    output logic              absent_o
);
    logic is_data;
    logic is_code;

    assign is_data  = (kind_i == KIND_DATA);
    assign is_code  = (kind_i == KIND_CODE);
    assign absent_o = !present_i;

    generate
        if (IS_STACK) begin : g_stack
            logic unused_stack;
            assign unused_stack = is_code ^ conforming_i;
            always_comb begin
                type_bad_o = !(is_data && rw_i);
                priv_bad_o = (rpl_i != cpl_i) || (dpl_i != cpl_i);
            end
        end else begin : g_data
            logic checked_kind;
            always_comb begin
                checked_kind = is_data || (is_code && !conforming_i);
                type_bad_o   = !(is_data || (is_code && rw_i));
                priv_bad_o   = checked_kind && ((rpl_i > dpl_i) || (cpl_i > dpl_i));
            end
        end
    endgenerate
endmodule

// File: rtl/srl_fault_prio.sv
module srl_fault_prio
    import srl_pkg::*;
(
    input  chk_flags_t flags_i,
    output fault_e     fault_o
);
    always_comb begin
        if (flags_i.ud)
            fault_o = FLT_UD;
        else if (!flags_i.desc_mode)
            fault_o = FLT_NONE;
        else if (flags_i.tbl_bad)
            fault_o = FLT_GP;
        else if (flags_i.null_bad)
            fault_o = FLT_GP;
        else if (flags_i.null_ok)
            fault_o = FLT_NONE;
        else if (flags_i.type_bad)
            fault_o = FLT_GP;
        else if (flags_i.priv_bad)
            fault_o = FLT_GP;
        else if (flags_i.absent)
            fault_o = flags_i.is_stack ? FLT_SS : FLT_NP;
        else
            fault_o = FLT_NONE;
    end
endmodule

// File: rtl/segload_check.sv
module segload_check
    import srl_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        tgt_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        opsize_i,
    input  logic              src_is_reg_i,
    input  logic [SEL_W-1:0]  selector_i,
    input  logic [1:0]        cpl_i,
    input  logic [1:0]        desc_kind_i,
    input  logic              desc_present_i,
    input  logic [1:0]        desc_dpl_i,
    input  logic              desc_rw_i,
    input  logic              desc_conforming_i,
    input  logic              tbl_over_i,
    input  logic              ldt_null_i,
    output logic              rsp_valid_o,
    output logic              seg_we_o,
    output logic              gpr_we_o,
    output logic              off_wide_o,
    output logic [FLT_W-1:0]  fault_o,
    output logic [SEL_W-1:0]  err_sel_o
);
    localparam logic [TGT_W-1:0] TGT_LAST = TGT_SS;

    typedef struct packed {
        logic             valid;
        logic             load;
        logic             wide;
        fault_e           fault;
        logic [SEL_W-1:0] err_sel;
    } rsp_t;

    logic [1:0]       sel_rpl;
    logic             sel_ti;
    logic             sel_null;
    logic [SEL_W-1:0] sel_err;

    logic stk_type_bad, stk_priv_bad, stk_absent;
    logic dat_type_bad, dat_priv_bad, dat_absent;

    chk_flags_t flags;
    fault_e     fault_now;
    rsp_t       rsp_d, rsp_q;

    srl_sel_decode #(.SEL_W(SEL_W)) u_dec (
        .sel_i     (selector_i),
        .rpl_o     (sel_rpl),
        .ti_o      (sel_ti),
        .is_null_o (sel_null),
        .err_sel_o (sel_err)
    );

    srl_seg_rules #(.IS_STACK(1'b1)) u_stack_rules (
        .kind_i       (desc_kind_i),
        .rw_i         (desc_rw_i),
        .conforming_i (desc_conforming_i),
        .present_i    (desc_present_i),
        .dpl_i        (desc_dpl_i),
        .rpl_i        (sel_rpl),
        .cpl_i        (cpl_i),
        .type_bad_o   (stk_type_bad),
        .priv_bad_o   (stk_priv_bad),
        .absent_o     (stk_absent)
    );

    srl_seg_rules #(.IS_STACK(1'b0)) u_data_rules (
        .kind_i       (desc_kind_i),
        .rw_i         (desc_rw_i),
        .conforming_i (desc_conforming_i),
        .present_i    (desc_present_i),
        .dpl_i        (desc_dpl_i),
        .rpl_i        (sel_rpl),
        .cpl_i        (cpl_i),
        .type_bad_o   (dat_type_bad),
        .priv_bad_o   (dat_priv_bad),
        .absent_o     (dat_absent)
    );

    // Gather the individual rule outcomes for the priority encoder
    always_comb begin
        flags.is_stack  = (tgt_i == TGT_SS);
        flags.ud        = src_is_reg_i
                        || (tgt_i > TGT_LAST)
                        || ((mode_i == MODE_L64) && ((tgt_i == TGT_DS) || (tgt_i == TGT_ES)));
        flags.desc_mode = (mode_i == MODE_PROT) || (mode_i == MODE_L64);
        flags.tbl_bad   = !sel_null && (tbl_over_i || (sel_ti && ldt_null_i));
        flags.null_bad  = sel_null && flags.is_stack
                        && ((mode_i != MODE_L64) || (cpl_i == PL_USER));
        flags.null_ok   = sel_null && !flags.null_bad;
        flags.type_bad  = flags.is_stack ? stk_type_bad : dat_type_bad;
        flags.priv_bad  = flags.is_stack ? stk_priv_bad : dat_priv_bad;
        flags.absent    = flags.is_stack ? stk_absent   : dat_absent;
    end

    srl_fault_prio u_prio (
        .flags_i (flags),
        .fault_o (fault_now)
    );

    always_comb begin
        rsp_d         = '0;
        rsp_d.valid   = req_valid_i;
        rsp_d.fault   = FLT_NONE;
        if (req_valid_i) begin
            rsp_d.fault = fault_now;
            rsp_d.load  = (fault_now == FLT_NONE);
            rsp_d.wide  = (fault_now == FLT_NONE) && (opsize_i != 2'd0);
            if ((fault_now != FLT_NONE) && (fault_now != FLT_UD))
                rsp_d.err_sel = sel_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign seg_we_o    = rsp_q.load;
    assign gpr_we_o    = rsp_q.load;
    assign off_wide_o  = rsp_q.wide;
    assign fault_o     = rsp_q.fault;
    assign err_sel_o   = rsp_q.err_sel;

endmodule

// File: rtl/srl_check_sva.sv
module srl_check_sva
    import srl_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [2:0]       tgt_i,
    input logic [1:0]       mode_i,
    input logic [1:0]       opsize_i,
    input logic             src_is_reg_i,
    input logic [SEL_W-1:0] selector_i,
    input logic             rsp_valid_o,
    input logic             seg_we_o,
    input logic             gpr_we_o,
    input logic             off_wide_o,
    input logic [2:0]       fault_o,
    input logic [SEL_W-1:0] err_sel_o
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !seg_we_o && !gpr_we_o && fault_o == 3'd0));

    assert_regsrc_ud_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && src_is_reg_i) |=> (fault_o == FLT_UD && err_sel_o == '0));

    assert_we_matches_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ((seg_we_o == (fault_o == 3'd0)) && (gpr_we_o == seg_we_o)));

    assert_narrow_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && opsize_i == 2'd0) |=> !off_wide_o);

    assert_real_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !src_is_reg_i && mode_i == MODE_REAL && tgt_i <= TGT_SS) |=> seg_we_o);

    assert_err_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !src_is_reg_i && tgt_i <= TGT_SS && mode_i == MODE_PROT)
        |=> (fault_o == 3'd0 || err_sel_o == {$past(selector_i[SEL_W-1:2]), 2'b00}));
endmodule

bind segload_check srl_check_sva #(.SEL_W(SEL_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .tgt_i        (tgt_i),
    .mode_i       (mode_i),
    .opsize_i     (opsize_i),
    .src_is_reg_i (src_is_reg_i),
    .selector_i   (selector_i),
    .rsp_valid_o  (rsp_valid_o),
    .seg_we_o     (seg_we_o),
    .gpr_we_o     (gpr_we_o),
    .off_wide_o   (off_wide_o),
    .fault_o      (fault_o),
    .err_sel_o    (err_sel_o)
);

// File: tb/sim_segload_check.sv
module sim_segload_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  tgt_i = '0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  opsize_i = '0;
    logic        src_is_reg_i = 1'b0;
    logic [15:0] selector_i = '0;
    logic [1:0]  cpl_i = '0;
    logic [1:0]  desc_kind_i = '0;
    logic        desc_present_i = 1'b0;
    logic [1:0]  desc_dpl_i = '0;
    logic        desc_rw_i = 1'b0;
    logic        desc_conforming_i = 1'b0;
    logic        tbl_over_i = 1'b0;
    logic        ldt_null_i = 1'b0;
    logic        rsp_valid_o, seg_we_o, gpr_we_o, off_wide_o;
    logic [2:0]  fault_o;
    logic [15:0] err_sel_o;

    int    checks = 0;
    int    failures = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // inputs seen at the last rising edge
    logic        p_valid, p_src, p_pres, p_rw, p_conf, p_over, p_ldtn;
    logic [2:0]  p_tgt;
    logic [1:0]  p_mode, p_op, p_cpl, p_kind, p_dpl;
    logic [15:0] p_sel;
    string       p_tag;

    segload_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .tgt_i(tgt_i),
        .mode_i(mode_i), .opsize_i(opsize_i), .src_is_reg_i(src_is_reg_i),
        .selector_i(selector_i), .cpl_i(cpl_i), .desc_kind_i(desc_kind_i),
        .desc_present_i(desc_present_i), .desc_dpl_i(desc_dpl_i),
        .desc_rw_i(desc_rw_i), .desc_conforming_i(desc_conforming_i),
        .tbl_over_i(tbl_over_i), .ldt_null_i(ldt_null_i),
        .rsp_valid_o(rsp_valid_o), .seg_we_o(seg_we_o), .gpr_we_o(gpr_we_o),
        .off_wide_o(off_wide_o), .fault_o(fault_o), .err_sel_o(err_sel_o)
    );

    always #5 clk = ~clk;

    // Reference decision, written from the requirement list
    function automatic int model_fault(
        input int t, input int m, input bit sr, input logic [15:0] s, input int c,
        input int k, input bit p, input int d, input bit rw, input bit cf,
        input bit ov, input bit ln);
        int  rpl;
        bit  nul;
        rpl = int'(s[1:0]);
        nul = (s[15:2] == 14'd0);
        if (sr || t >= 5 || (m == 3 && (t == 0 || t == 1))) return 1;   // R2
        if (m == 0 || m == 1) return 0;                                  // R4
        if (!nul && (ov || (s[2] && ln))) return 2;                      // R5
        if (t == 4) begin
            if (nul) return (m != 3 || c == 3) ? 2 : 0;                  // R6
            if (k != 1 || !rw) return 2;                                 // R7
            if (rpl != c || d != c) return 2;                            // R8
            if (!p) return 3;                                            // R9
            return 0;
        end
        if (nul) return 0;                                               // R6
        if (!(k == 1 || (k == 2 && rw))) return 2;                       // R10
        if ((k == 1 || !cf) && (rpl > d || c > d)) return 2;             // R11
        if (!p) return 4;                                                // R12
        return 0;
    endfunction

    always @(posedge clk) begin
        p_valid <= req_valid_i; p_src <= src_is_reg_i; p_pres <= desc_present_i;
        p_rw <= desc_rw_i; p_conf <= desc_conforming_i; p_over <= tbl_over_i;
        p_ldtn <= ldt_null_i; p_tgt <= tgt_i; p_mode <= mode_i; p_op <= opsize_i;
        p_cpl <= cpl_i; p_kind <= desc_kind_i; p_dpl <= desc_dpl_i;
        p_sel <= selector_i; p_tag <= tag;
    end

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            int          ef;
            bit          el, ew;
            logic [15:0] ee;
            ef = p_valid ? model_fault(int'(p_tgt), int'(p_mode), p_src, p_sel, int'(p_cpl),
                                       int'(p_kind), p_pres, int'(p_dpl), p_rw, p_conf,
                                       p_over, p_ldtn) : 0;
            el = p_valid && ef == 0;
            ew = el && p_op != 2'd0;
            ee = (p_valid && ef > 1) ? {p_sel[15:2], 2'b00} : 16'h0;
            checks++;
            if (rsp_valid_o !== p_valid || seg_we_o !== el || gpr_we_o !== el ||
                off_wide_o !== ew || fault_o !== 3'(ef) || err_sel_o !== ee) begin
                failures++;
                $display("FAIL %s: got v=%b we=%b/%b wide=%b fault=%0d err=%h exp v=%b we=%b wide=%b fault=%0d err=%h",
                         p_tag, rsp_valid_o, seg_we_o, gpr_we_o, off_wide_o, fault_o, err_sel_o,
                         p_valid, el, ew, ef, ee);
            end
        end
    end

    task automatic good_defaults();
        tgt_i = 3'd0; mode_i = 2'd2; opsize_i = 2'd1; src_is_reg_i = 1'b0;
        selector_i = 16'h0013; cpl_i = 2'd3; desc_kind_i = 2'd1; desc_present_i = 1'b1;
        desc_dpl_i = 2'd3; desc_rw_i = 1'b1; desc_conforming_i = 1'b0;
        tbl_over_i = 1'b0; ldt_null_i = 1'b0;
    endtask

    task automatic fire(input string t);
        tag = t;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        good_defaults();
    endtask

    initial begin
        good_defaults();
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (rsp_valid_o !== 1'b0 || seg_we_o !== 1'b0 || fault_o !== 3'd0 || err_sel_o !== 16'h0) begin
            failures++;
            $display("FAIL R1 reset: got v=%b we=%b fault=%0d err=%h exp all zero",
                     rsp_valid_o, seg_we_o, fault_o, err_sel_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        tag = "R1";
        repeat (2) @(negedge clk);

        // R1 / R3 basic loads
        fire("R1");
        good_defaults(); opsize_i = 2'd0; fire("R3");
        good_defaults(); opsize_i = 2'd2; tgt_i = 3'd2; mode_i = 2'd3; fire("R3");
        good_defaults(); tgt_i = 3'd3; fire("R3");
        // R2 invalid opcode
        good_defaults(); src_is_reg_i = 1'b1; fire("R2");
        good_defaults(); tgt_i = 3'd6; fire("R2");
        good_defaults(); tgt_i = 3'd7; mode_i = 2'd0; fire("R2");
        good_defaults(); tgt_i = 3'd1; mode_i = 2'd3; fire("R2");
        good_defaults(); tgt_i = 3'd0; mode_i = 2'd3; fire("R2");
        // R4 real and virtual-8086 ignore descriptor inputs
        good_defaults(); mode_i = 2'd0; desc_present_i = 1'b0; tbl_over_i = 1'b1; desc_kind_i = 2'd0; fire("R4");
        good_defaults(); mode_i = 2'd1; tgt_i = 3'd4; selector_i = 16'h0000; fire("R4");
        // R5 table checks
        good_defaults(); tbl_over_i = 1'b1; selector_i = 16'h1233; fire("R5");
        good_defaults(); selector_i = 16'h0017; ldt_null_i = 1'b1; fire("R5");
        good_defaults(); selector_i = 16'h0017; fire("R5");
        // R6 null selectors
        good_defaults(); selector_i = 16'h0003; tbl_over_i = 1'b1; desc_present_i = 1'b0; fire("R6");
        good_defaults(); tgt_i = 3'd4; selector_i = 16'h0002; cpl_i = 2'd0; fire("R6");
        good_defaults(); tgt_i = 3'd4; mode_i = 2'd3; selector_i = 16'h0000; cpl_i = 2'd0; fire("R6");
        good_defaults(); tgt_i = 3'd4; mode_i = 2'd3; selector_i = 16'h0003; fire("R6");
        // R7 stack type
        good_defaults(); tgt_i = 3'd4; desc_kind_i = 2'd2; fire("R7");
        good_defaults(); tgt_i = 3'd4; desc_rw_i = 1'b0; fire("R7");
        good_defaults(); tgt_i = 3'd4; fire("R7");
        // R8 stack privilege
        good_defaults(); tgt_i = 3'd4; selector_i = 16'h0011; fire("R8");
        good_defaults(); tgt_i = 3'd4; desc_dpl_i = 2'd2; fire("R8");
        good_defaults(); tgt_i = 3'd4; cpl_i = 2'd0; selector_i = 16'h0010; desc_dpl_i = 2'd0; fire("R8");
        // R9 stack absent
        good_defaults(); tgt_i = 3'd4; desc_present_i = 1'b0; fire("R9");
        // R10 data register type
        good_defaults(); desc_kind_i = 2'd0; fire("R10");
        good_defaults(); desc_kind_i = 2'd3; fire("R10");
        good_defaults(); desc_kind_i = 2'd2; desc_rw_i = 1'b0; fire("R10");
        good_defaults(); desc_kind_i = 2'd2; fire("R10");
        // R11 data register privilege
        good_defaults(); desc_dpl_i = 2'd0; fire("R11");
        good_defaults(); cpl_i = 2'd0; desc_dpl_i = 2'd1; selector_i = 16'h0012; fire("R11");
        good_defaults(); desc_kind_i = 2'd2; desc_conforming_i = 1'b1; desc_dpl_i = 2'd0; fire("R11");
        good_defaults(); desc_kind_i = 2'd2; desc_dpl_i = 2'd0; fire("R11");
        // R12 data register absent
        good_defaults(); tgt_i = 3'd5 - 3'd3; desc_present_i = 1'b0; fire("R12");
        // R13 priority
        good_defaults(); src_is_reg_i = 1'b1; tbl_over_i = 1'b1; desc_present_i = 1'b0; fire("R13");
        good_defaults(); tbl_over_i = 1'b1; desc_kind_i = 2'd0; desc_present_i = 1'b0; fire("R13");
        good_defaults(); tgt_i = 3'd4; desc_rw_i = 1'b0; selector_i = 16'h0010; desc_present_i = 1'b0; fire("R13");
        good_defaults(); desc_dpl_i = 2'd0; desc_present_i = 1'b0; fire("R13");
        good_defaults(); tgt_i = 3'd4; selector_i = 16'h0000; ldt_null_i = 1'b1; desc_present_i = 1'b0; fire("R13");

        // Back-to-back randomized traffic (R13 and all rules)
        tag = "R13";
        for (int i = 0; i < 4000; i++) begin
            req_valid_i       = ($urandom % 5) != 0;
            tgt_i             = 3'($urandom % 8);
            mode_i            = 2'($urandom);
            opsize_i          = 2'($urandom);
            src_is_reg_i      = ($urandom % 8) == 0;
            selector_i        = ($urandom % 4 == 0) ? 16'($urandom % 4) : 16'($urandom);
            cpl_i             = 2'($urandom);
            desc_kind_i       = 2'($urandom);
            desc_present_i    = ($urandom % 6) != 0;
            desc_dpl_i        = 2'($urandom);
            desc_rw_i         = ($urandom % 4) != 0;
            desc_conforming_i = 1'($urandom);
            tbl_over_i        = ($urandom % 8) == 0;
            ldt_null_i        = ($urandom % 6) == 0;
            @(negedge clk);
        end
        req_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule